// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block sits beside a small 8-bit processor core and decides which interrupt the core should service next. Each peripheral source sends a one-cycle event pulse. The block records that pulse in a pending flag, whatever the state of the masks. One external input is level-sensitive and has no flag. It counts as pending only while the pin is high and its enable bit is set. The block combines the flags with a per-source mask and a single global enable. It then raises a request to the core together with a vector index. The lowest index wins, and the external input owns index 0.

When the core signals that it has taken the vector, the block clears the global enable and the flag of the source it served. Only a return-from-interrupt strobe or a software write sets the enable again. Flags that were recorded while interrupts were blocked are then served one at a time in priority order. Software reaches four byte-wide registers through a simple write-strobe and address port, and reads them back combinationally. Register 0 is the external enable, with only bit 6 used. Register 1 is the source mask, with bit i belonging to source i. Register 2 holds the flags, which software clears by writing ones. Register 3 is control, with bit 0 as the global enable. The status register of the core is never saved or restored here.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq_req` is low.
- R2: An event pulse on `src_evt[i]` sets flag bit i (register 2), even when mask bit i or the global enable is zero. The flag stays set until something clears it.
- R3: A write to register 2 clears each flag whose data bit is one and leaves the flags whose data bit is zero unchanged. If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R4: `irq_req` rises on the clock edge that makes the global enable 1 while an enabled source is pending, or on the edge after a source becomes pending while the enable is already 1. `irq_vec` is then the lowest pending, enabled index. Source i uses index i+1 and the external input uses index 0. `irq_req` is never high while the global enable is 0.
- R5: While `irq_req` is high and `vec_taken` is low, `irq_vec` does not change, even if a higher-priority source becomes pending.
- R6: A `vec_taken` pulse drops `irq_req` and clears the global enable (register 3 bit 0) at the next edge. It also clears the flag of the source that was presented.
- R7: A `reti` pulse sets the global enable. A software write to register 3 sets or clears it from data bit 0.
- R8: The external request (index 0) is pending only while `ext_lvl` is high and register 0 bit 6 is one. Dropping `ext_lvl` removes the request at the next edge. Taking vector 0 clears no flag, and index 0 beats every flagged source.
- R9: Only bit 6 of register 0 can be written; all other bits of that register read zero.
- R10: Flags recorded while the global enable is off are served one per enable/take cycle, in ascending index order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | NUM_SRC | One-cycle event pulses from flagged sources |
| ext_lvl | input | 1 | Level-sensitive external request |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| vec_taken | input | 1 | Core has vectored to `irq_vec` |
| reti | input | 1 | Core returned from a handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Vector index of the presented request |

## Verification
The embedded assertions check these properties on every cycle:
- A take clears the global enable.
- A lone return sets the global enable.
- The request never rises while the enable is off.
- The vector stays stable while the request is high.
- An event always leaves its flag set, and a hardware clear without a same-cycle event leaves the flag clear.

Only the directed scenarios can show the properties that depend on ordering and history:
- The ascending order in which a backlog of flags is drained.
- External index 0 beating the timer sources.
- Clears by writing ones, and the write mask of register 0.
- The fact that a dropped level input leaves no trace behind.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int REG_ADDR_W = 2;
    localparam int REG_DATA_W = 8;

    localparam logic [REG_ADDR_W-1:0] ADDR_EXT_EN   = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_SRC_MASK = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_FLAGS    = 2'd2;
    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL     = 2'd3;

    localparam int EXT_EN_BIT = 6;
    localparam int GIE_BIT    = 0;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] w1c_i,
    input  logic [N-1:0] hwclr_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a new event beats any same-cycle clear
        st_d.flags = (st_q.flags & ~(w1c_i | hwclr_i)) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flags_o[g]);
        assert_hw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (hwclr_i[g] && !set_i[g]) |=> !flags_o[g]);
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        valid_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_evt,
    input  logic                  ext_lvl,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    input  logic                  vec_taken,
    input  logic                  reti,
    output logic                  irq_req,
    output logic [VEC_W-1:0]      irq_vec
);
    localparam int NUM_VEC = NUM_SRC + 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] src_mask;
        logic               ext_en;
        logic               gie;
        logic               active;
        logic [VEC_W-1:0]   vec;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] w1c;
    logic [NUM_SRC-1:0] hwclr;
    logic [NUM_VEC-1:0] pend_en;
    logic               win_valid;
    logic [VEC_W-1:0]   win_idx;
    logic               hold_ok;

    irq_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (src_evt),
        .w1c_i   (w1c),
        .hwclr_i (hwclr),
        .flags_o (flags)
    );

    assign pend_en = {flags & ctl_q.src_mask, ext_lvl & ctl_q.ext_en};

    irq_prio_pick #(.N(NUM_VEC), .IDX_W(VEC_W)) u_pick (
        .req_i   (pend_en),
        .valid_o (win_valid),
        .idx_o   (win_idx)
    );

    always_comb begin
        w1c = '0;
        if (reg_wr && reg_addr == ADDR_FLAGS) w1c = reg_wdata[NUM_SRC-1:0];
        for (int i = 0; i < NUM_SRC; i++) begin
            hwclr[i] = vec_taken && ctl_q.active && (ctl_q.vec == VEC_W'(i + 1));
        end
        hold_ok = 1'b0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (ctl_q.vec == VEC_W'(i)) hold_ok = pend_en[i];
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr && reg_addr == ADDR_EXT_EN)   ctl_d.ext_en   = reg_wdata[EXT_EN_BIT];
        if (reg_wr && reg_addr == ADDR_SRC_MASK) ctl_d.src_mask = reg_wdata[NUM_SRC-1:0];

        if (vec_taken)                         ctl_d.gie = 1'b0;
        else if (reti)                         ctl_d.gie = 1'b1;
        else if (reg_wr && reg_addr == ADDR_CTRL) ctl_d.gie = reg_wdata[GIE_BIT];

        if (vec_taken || !ctl_d.gie) begin
            ctl_d.active = 1'b0;
        end else if (ctl_q.active) begin
            // keep the presented vector; drop for a cycle if it vanished
            ctl_d.active = hold_ok;
        end else begin
            ctl_d.active = win_valid;
            if (win_valid) ctl_d.vec = win_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_EXT_EN:   reg_rdata[EXT_EN_BIT]     = ctl_q.ext_en;
            ADDR_SRC_MASK: reg_rdata[NUM_SRC-1:0]    = ctl_q.src_mask;
            ADDR_FLAGS:    reg_rdata[NUM_SRC-1:0]    = flags;
            default:       reg_rdata[GIE_BIT]        = ctl_q.gie;
        endcase
    end

    assign irq_req = ctl_q.active;
    assign irq_vec = ctl_q.vec;

    assert_take_drops_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_taken |=> (!ctl_q.gie && !irq_req));
    assert_reti_sets_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !vec_taken) |=> ctl_q.gie);
    assert_req_needs_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ctl_q.gie);
    assert_vec_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !vec_taken) |=> (!irq_req || $stable(irq_vec)));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 4;
    localparam int VW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_evt = '0;
    logic            ext_lvl = 1'b0;
    logic [1:0]      reg_addr = '0;
    logic            reg_wr = 1'b0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic            vec_taken = 1'b0;
    logic            reti = 1'b0;
    logic            irq_req;
    logic [VW-1:0]   irq_vec;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(NSRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .ext_lvl(ext_lvl),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .vec_taken(vec_taken), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic pulse_evt(input logic [NSRC-1:0] m);
        src_evt = m; tick(1); src_evt = '0;
    endtask

    task automatic take();
        vec_taken = 1'b1; tick(1); vec_taken = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1; tick(1); reti = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        check("R1 irq_req", int'(irq_req), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 register", v, 0);
        end
    endtask

    task automatic t_masked_flag();
        int v;
        pulse_evt(4'b0100);
        rd(2, v);
        check("R2 flag set while masked", v, 8'h04);
        tick(2);
        check("R2 no request while masked", int'(irq_req), 0);
        rd(2, v);
        check("R2 flag persists", v, 8'h04);
    endtask

    task automatic t_w1c();
        int v;
        wr(2, 8'h00);
        rd(2, v);
        check("R3 zero write keeps flag", v, 8'h04);
        wr(2, 8'h04);
        rd(2, v);
        check("R3 one write clears flag", v, 8'h00);
        src_evt = 4'b0010;
        wr(2, 8'h02);
        src_evt = '0;
        rd(2, v);
        check("R3 set beats clear", v, 8'h02);
    endtask

    task automatic t_priority();
        int v;
        wr(1, 8'h0F);
        pulse_evt(4'b1000);
        check("R4 no request with gie off", int'(irq_req), 0);
        wr(3, 8'h01);
        check("R4 request raised", int'(irq_req), 1);
        check("R4 lowest index wins", int'(irq_vec), 2);
        pulse_evt(4'b0001);
        tick(2);
        check("R5 request still high", int'(irq_req), 1);
        check("R5 vector held", int'(irq_vec), 2);
        take();
        check("R6 request dropped", int'(irq_req), 0);
        rd(3, v);
        check("R6 gie cleared", v, 0);
        rd(2, v);
        check("R6 served flag cleared", v, 8'h09);
        do_reti();
        rd(3, v);
        check("R7 reti sets gie", v, 1);
        check("R10 next request", int'(irq_req), 1);
        check("R10 next vector", int'(irq_vec), 1);
        take();
        do_reti();
        check("R10 last vector", int'(irq_vec), 4);
        take();
        rd(2, v);
        check("R10 backlog drained", v, 0);
    endtask

    task automatic t_ext();
        int v;
        wr(0, 8'hFF);
        rd(0, v);
        check("R9 only bit 6 writable", v, 8'h40);
        wr(3, 8'h01);
        ext_lvl = 1'b1;
        tick(1);
        check("R8 ext request", int'(irq_req), 1);
        check("R8 ext vector", int'(irq_vec), 0);
        ext_lvl = 1'b0;
        tick(1);
        check("R8 ext forgotten", int'(irq_req), 0);
        rd(2, v);
        check("R8 ext has no flag", v, 0);
        wr(3, 8'h00);
        rd(3, v);
        check("R7 software clears gie", v, 0);
        pulse_evt(4'b0100);
        ext_lvl = 1'b1;
        wr(3, 8'h01);
        check("R8 ext beats sources", int'(irq_vec), 0);
        take();
        rd(2, v);
        check("R8 take of ext keeps flags", v, 8'h04);
        wr(0, 8'h00);
        do_reti();
        check("R8 disabled ext ignored", int'(irq_vec), 3);
        check("R8 source request", int'(irq_req), 1);
        take();
        ext_lvl = 1'b0;
        rd(2, v);
        check("R6 flag 2 cleared", v, 0);
    endtask

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_masked_flag();
        t_w1c();
        t_priority();
        t_ext();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule